// File: doc/BRIEF.md
# Sticky Interrupt Status Controller

This block gathers single-cycle event pulses from an audio transmitter, an audio receiver and a sample rate converter into one 8-bit interrupt status register. Every status bit captures its event and holds it until the host reads the status register. A read both returns the held value and clears the register. An event that arrives in the same cycle as that read still lands, so it is not lost.

A 3-bit mask register selects which converter error sources (left overrange, right overrange, mute indication) may set the converter summary bit. An active-high interrupt line is driven from every status bit except the receive channel-status mismatch bit. That bit is recorded but kept silent.

The receive channel-status block bit has two modes, chosen by a configuration input. In one mode it reports every new block. In the other it reports only blocks whose 24-bit content differs from the previous block. The host reaches both registers over a plain bus with a 7-bit address, 8-bit data, and read and write strobes.

Top module: `irq_status_ctrl`

## Requirements
- R1: Read data is combinational from `bus_addr`. Address 0x1C returns the status register. Address 0x1B returns the mask register. Any other address returns 0x00. A write to the status address changes nothing.
- R2: Status bit layout: 7 converter summary, 6 transmit collision, 5 transmit user buffer empty, 4 transmit channel-status block sent, 3 receive A/B mismatch, 2 receive user block new, 1 receive channel-status block, 0 receive error. An event input that is high at a clock edge sets its bit, and the bit is visible after that edge.
- R3: A set status bit stays set on every later cycle until a read strobe addresses 0x1C. On that edge all bits clear, and the read data during the strobe shows the values held before the clear.
- R4: If an event is high on the same edge that a status read clears the register, its bit is 1 after that edge.
- R5: A write to 0x1B stores `bus_wdata[2:0]` in the mask. Bits 7..3 read back as 0. The mask is 0 after reset.
- R6: Status bit 7 sets when any converter source is high while its mask bit is 1. Mask bit 2 gates the left overrange source, bit 1 the right overrange source, and bit 0 the mute source. A source whose mask bit is 0 has no effect.
- R7: Status bit 3 never drives `irq` high.
- R8: `irq` is high exactly when any of status bits 7, 6, 5, 4, 2, 1 or 0 is 1.
- R9: When `cs_change_mode` is 0, every `rx_cs_block` pulse sets status bit 1. When it is 1, a pulse sets bit 1 only if `rx_cs_data` differs from the snapshot taken at the previous pulse. The snapshot updates on every pulse and is 0 after reset.
- R10: Status bit 6 sets only when `tx_cs_wr` and `tx_cs_busy` are high together. Either one alone does not set it.
- R11: An asynchronous low on `rst_n` clears the status register, the mask and the channel-status snapshot at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 7 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; clears the status register when it addresses it |
| bus_rdata | output | 8 | Read data |
| irq | output | 1 | Active-high interrupt |
| tx_cs_wr | input | 1 | Host write into the transmit channel-status buffer |
| tx_cs_busy | input | 1 | Copy from the transmit channel-status buffer to the output buffer in progress |
| tx_ub_empty | input | 1 | Transmit user buffer empty |
| tx_cs_sent | input | 1 | Transmit channel-status block sent |
| rx_cs_mismatch | input | 1 | Receive channel-status A and B blocks differ |
| rx_ub_new | input | 1 | Receive user buffer has a new block |
| rx_cs_block | input | 1 | New receive channel-status block available |
| rx_cs_data | input | 24 | Receive channel-status snapshot |
| cs_change_mode | input | 1 | 1: report only changed channel-status blocks |
| rx_err | input | 1 | Receive error summary |
| src_ovr_left | input | 1 | Converter left overrange |
| src_ovr_right | input | 1 | Converter right overrange |
| src_mute | input | 1 | Converter mute indication |

## Verification
The assertions assume that all inputs are synchronous to `clk` and settle before each rising edge. They also assume that `bus_rd` and `bus_wr` are never high together on the same address.

The bench drives every input on the falling edge and never raises both strobes at once, so it stays within these assumptions. Event inputs are held for a single cycle and then returned to 0. This lets each expected status value follow directly from the pulses driven since the last clearing read.

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
  parameter int ADDR_W = 7,
  parameter int CS_W = 24,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 7'h1C,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 7'h1B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  output logic              irq,
  input  logic              tx_cs_wr,
  input  logic              tx_cs_busy,
  input  logic              tx_ub_empty,
  input  logic              tx_cs_sent,
  input  logic              rx_cs_mismatch,
  input  logic              rx_ub_new,
  input  logic              rx_cs_block,
  input  logic [CS_W-1:0]   rx_cs_data,
  input  logic              cs_change_mode,
  input  logic              rx_err,
  input  logic              src_ovr_left,
  input  logic              src_ovr_right,
  input  logic              src_mute
);
  localparam logic [7:0] IRQ_EN = 8'hF7;

  logic [7:0]      status_q;
  logic [2:0]      mask_q;
  logic [CS_W-1:0] cs_prev_q;

  wire       stat_sel = bus_addr == STAT_ADDR;
  wire       mask_sel = bus_addr == MASK_ADDR;
  wire       clr      = bus_rd && stat_sel;
  wire [2:0] src_vec  = {src_ovr_left, src_ovr_right, src_mute};
  wire       cs_new   = rx_cs_block && (!cs_change_mode || rx_cs_data != cs_prev_q);
  wire [7:0] set_vec  = {|(src_vec & mask_q), tx_cs_wr & tx_cs_busy, tx_ub_empty,
                         tx_cs_sent, rx_cs_mismatch, rx_ub_new, cs_new, rx_err};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q  <= '0;
      mask_q    <= '0;
      cs_prev_q <= '0;
    end else begin
      status_q <= (status_q & ~{8{clr}}) | set_vec;
      if (bus_wr && mask_sel) mask_q <= bus_wdata[2:0];
      if (rx_cs_block) cs_prev_q <= rx_cs_data;
    end
  end

  assign irq       = |(status_q & IRQ_EN);
  assign bus_rdata = stat_sel ? status_q : (mask_sel ? {5'b0, mask_q} : 8'h00);

  AST_EVENT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |=> status_q[0]); // R2
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (($past(status_q) & ~status_q) == 8'h00)); // R3
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && set_vec == 8'h00) |=> status_q == 8'h00); // R3
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && tx_ub_empty) |=> status_q[5]); // R4
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mask_sel |-> bus_rdata[7:3] == 5'b0); // R5
  AST_MASK_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_vec & mask_q) == 3'b0 && !status_q[7]) |=> !status_q[7]); // R6
  AST_MISMATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == 8'h08) |-> !irq); // R7
  AST_CS_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_change_mode && rx_cs_block && rx_cs_data == cs_prev_q && !status_q[1]) |=> !status_q[1]); // R9
  AST_NO_LONE_COLLISION: assert property (@(posedge clk) disable iff (!rst_n)
    (!(tx_cs_wr && tx_cs_busy) && !status_q[6]) |=> !status_q[6]); // R10
endmodule

// File: tb/irq_status_ctrl_bench.sv
module irq_status_ctrl_bench;
  logic clk = 0, rst_n = 0;
  logic [6:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic bus_wr = 0, bus_rd = 0, irq;
  logic tx_cs_wr = 0, tx_cs_busy = 0, tx_ub_empty = 0, tx_cs_sent = 0;
  logic rx_cs_mismatch = 0, rx_ub_new = 0, rx_cs_block = 0, cs_change_mode = 0, rx_err = 0;
  logic [23:0] rx_cs_data = 0;
  logic src_ovr_left = 0, src_ovr_right = 0, src_mute = 0;
  int checks = 0, failures = 0;
  bit done = 0;

  localparam logic [6:0] STAT = 7'h1C, MASK = 7'h1B;

  always #5 clk = ~clk;

  irq_status_ctrl u_irq_status_ctrl (.*);

  // {mask[2:0], src{L,R,M}, ev{cs_wr,busy,ub_empty,sent,mis,ub_new,err}, exp_status, exp_irq}
  localparam int NV = 14;
  localparam logic [21:0] VEC [NV] = '{
    {3'b000, 3'b111, 7'b0000000, 8'h00, 1'b0},
    {3'b100, 3'b100, 7'b0000000, 8'h80, 1'b1},
    {3'b100, 3'b011, 7'b0000000, 8'h00, 1'b0},
    {3'b011, 3'b001, 7'b0000000, 8'h80, 1'b1},
    {3'b010, 3'b010, 7'b0000000, 8'h80, 1'b1},
    {3'b000, 3'b000, 7'b0000001, 8'h01, 1'b1},
    {3'b000, 3'b000, 7'b0000010, 8'h04, 1'b1},
    {3'b000, 3'b000, 7'b0000100, 8'h08, 1'b0},
    {3'b000, 3'b000, 7'b0001000, 8'h10, 1'b1},
    {3'b000, 3'b000, 7'b0010000, 8'h20, 1'b1},
    {3'b000, 3'b000, 7'b1000000, 8'h00, 1'b0},
    {3'b000, 3'b000, 7'b0100000, 8'h00, 1'b0},
    {3'b000, 3'b000, 7'b1100000, 8'h40, 1'b1},
    {3'b000, 3'b000, 7'b0000101, 8'h09, 1'b1}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic write_reg(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic peek(input logic [6:0] a, output logic [7:0] d);
    bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic read_stat(input string tag, input logic [7:0] exp);
    @(negedge clk); bus_addr = STAT; bus_rd = 1;
    #1 chk(tag, bus_rdata, exp);
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic set_ev(input logic [6:0] e);
    {tx_cs_wr, tx_cs_busy, tx_ub_empty, tx_cs_sent, rx_cs_mismatch, rx_ub_new, rx_err} = e;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    #3;
    peek(STAT, d); chk("R11 reset status", d, 8'h00);
    peek(MASK, d); chk("R11 reset mask R5", d, 8'h00);
    chk("R8 reset irq", {7'b0, irq}, 8'h00);
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      write_reg(MASK, {5'b0, VEC[i][21:19]});
      @(negedge clk);
      {src_ovr_left, src_ovr_right, src_mute} = VEC[i][18:16];
      set_ev(VEC[i][15:9]);
      @(negedge clk);
      {src_ovr_left, src_ovr_right, src_mute} = 3'b0;
      set_ev(7'b0);
      chk($sformatf("R2 R6 R7 R8 R10 irq vec%0d", i), {7'b0, irq}, {7'b0, VEC[i][0]});
      read_stat($sformatf("R2 R6 R10 status vec%0d", i), VEC[i][8:1]);
      peek(STAT, d); chk($sformatf("R3 cleared vec%0d", i), d, 8'h00);
    end

    write_reg(MASK, 8'hFF);
    peek(MASK, d); chk("R5 reserved bits zero", d, 8'h07);
    peek(7'h00, d); chk("R1 unmapped address", d, 8'h00);
    write_reg(STAT, 8'hFF);
    peek(STAT, d); chk("R1 status write ignored", d, 8'h00);

    @(negedge clk); rx_ub_new = 1;
    @(negedge clk); rx_ub_new = 0;
    repeat (3) @(negedge clk);
    peek(STAT, d); chk("R3 sticky after idle cycles", d, 8'h04);
    @(negedge clk); bus_addr = STAT; bus_rd = 1; rx_err = 1;
    #1 chk("R4 read returns old value", bus_rdata, 8'h04);
    @(negedge clk); bus_rd = 0; rx_err = 0;
    read_stat("R4 set wins over clear", 8'h01);

    cs_change_mode = 0;
    @(negedge clk); rx_cs_block = 1; rx_cs_data = 24'h00A5A5;
    @(negedge clk); rx_cs_block = 0;
    read_stat("R9 mode0 first block", 8'h02);
    @(negedge clk); rx_cs_block = 1;
    @(negedge clk); rx_cs_block = 0;
    read_stat("R9 mode0 same block", 8'h02);
    cs_change_mode = 1;
    @(negedge clk); rx_cs_block = 1;
    @(negedge clk); rx_cs_block = 0;
    read_stat("R9 mode1 unchanged", 8'h00);
    @(negedge clk); rx_cs_block = 1; rx_cs_data = 24'h00A5A4;
    @(negedge clk); rx_cs_block = 0;
    read_stat("R9 mode1 changed", 8'h02);

    @(negedge clk); rx_err = 1; src_mute = 1;
    @(negedge clk); rx_err = 0; src_mute = 0;
    #2 rst_n = 0;
    #1 peek(STAT, d); chk("R11 async clear status", d, 8'h00);
    peek(MASK, d); chk("R11 async clear mask", d, 8'h00);
    chk("R11 irq low in reset", {7'b0, irq}, 8'h00);
    @(negedge clk); rst_n = 1;
    @(negedge clk); rx_cs_block = 1; rx_cs_data = 24'h0;
    @(negedge clk); rx_cs_block = 0;
    read_stat("R11 snapshot cleared", 8'h00);

    finish_run();
  end
endmodule